// File: doc/BRIEF.md
# DQS Gate Calibration Sequencer

This block runs read-strobe gate (squelch) calibration on a DRAM PHY that has two byte lanes. The memory controller has to be parked in its configuration state before the sequence starts. Automatic refresh cannot run while the PHY calibrates, so the block suspends it for that time. On a start pulse the block reads the live refresh-interval value and saves it. It then writes zero to the interval register, which stops automatic refresh. Next it raises the calibration request to the PHY and waits until every byte lane reports that it is finished.

When calibration finishes, the block drops the request. It then sends a fixed number of all-rank refresh commands, one after another, through a request/acknowledge command port. These make up for the roughly 20 µs of refresh that was skipped against a 7.8 µs refresh period. Last, it writes the saved interval back and pulses `done_o` for one cycle.

If the lanes never all report done, a timeout counter ends the wait. In that case the block skips the catch-up refreshes, restores the interval, and raises `err_o`. The error flag stays set until the next accepted start.

Top module: `dqs_gate_cal_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, ivl_wr_en_o and ref_req_o are 0, and cal_ctrl_o is 2'b00.
- R2: A start accepted while idle is followed on the next cycle by a write of zero to the refresh interval (ivl_wr_en_o=1, ivl_wr_data_o=0). The interval value is sampled in that same cycle. This write comes before calibration is requested.
- R3: During calibration cal_ctrl_o is 2'b01: bit 0 set means calibrate. Bit 1 is the mode bit, and 0 selects normal mode; it stays 0 at all times. No refresh request and no interval write happen while bit 0 is set.
- R4: Calibration ends only once cal_stat_i is 2'b11 (bit 1 is the upper lane, bit 0 the lower lane). One lane alone does not end it, unless the timeout expires.
- R5: After a successful calibration, cal_ctrl_o returns to 2'b00. Exactly NUM_REF (default 3) refresh requests follow, each with ref_rank_o all ones (every rank).
- R6: A refresh request stays high until it is acknowledged, and the next request starts only after that acknowledge.
- R7: The saved interval value is written back once, after the last refresh acknowledge, in the same cycle as done_o.
- R8: If cal_stat_i does not reach 2'b11 within CAL_TIMEOUT cycles of calibration request, cal_ctrl_o bit 0 drops after exactly CAL_TIMEOUT cycles. No refresh is issued, the interval is restored, done_o pulses and err_o is set.
- R9: done_o is a one-cycle pulse, once per sequence. A start while busy_o is 1 is ignored.
- R10: err_o holds after a timeout until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence timed out |
| ivl_rd_i | input | IVL_W | Current refresh-interval register value |
| ivl_wr_en_o | output | 1 | Refresh-interval write strobe |
| ivl_wr_data_o | output | IVL_W | Refresh-interval write value |
| cal_ctrl_o | output | 2 | PHY calibration control: bit 0 calibrate, bit 1 mode (0 normal) |
| cal_stat_i | input | 2 | PHY lane done flags: bit 1 upper, bit 0 lower |
| ref_req_o | output | 1 | Refresh command request |
| ref_rank_o | output | RANK_W | Rank select for refresh (all ones) |
| ref_ack_i | input | 1 | Refresh command complete |

## Verification
The bench sweeps the lower and upper lane completion delays, including lanes that never report, together with several acknowledge latencies and preset interval values, including zero and all ones. Four faults are targeted:
- A design that accepted one lane as done would end calibration early. The bench catches this as a drop of the calibrate bit before both flags are high.
- A design that restored the interval too early would show the restore before the last acknowledge.
- A miscounted burst would give the wrong number of refresh requests.
- An off-by-one timeout would hold the calibrate bit for the wrong number of cycles.

A start pulse in mid-sequence, and the err_o flag held after a timeout and cleared by the next run, are also covered.

// File: rtl/dqs_cal_pkg.sv
// Shared types for the DQS gate calibration sequencer.
// Assumes: a single clock domain; the FSM state is the only shared type.
package dqs_cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_CAL,
        ST_REF,
        ST_RESTORE
    } seq_state_e;

    // Bit positions of the PHY calibration control field
    localparam int CAL_GO_BIT   = 0;
    localparam int CAL_MODE_BIT = 1;
endpackage

// File: rtl/dqs_cal_timer.sv
// Calibration wait timer.
// Counts the cycles spent with enable high and flags expiry on the last
// allowed cycle. Clears whenever enable is low.
// Assumes: TIMEOUT >= 1.
module dqs_cal_timer #(
    parameter int TIMEOUT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    // cycle counter for the current wait
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // expiry on the final cycle of the window
    always_comb expire = en && (cnt == LAST);
endmodule

// File: rtl/dqs_cal_ref_issuer.sv
// Catch-up refresh issuer.
// While go is high it sends NUM_REF refresh requests, one at a time. Each
// request is held until it is acknowledged. fin rises once all of them have
// been acknowledged. Dropping go clears the issuer.
// Assumes: ack is only meaningful while req is high.
module dqs_cal_ref_issuer #(
    parameter int NUM_REF = 3,
    parameter int RANK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              ack,
    output logic              req,
    output logic [RANK_W-1:0] rank,
    output logic              fin
);
    localparam int NW = $clog2(NUM_REF + 1);
    localparam logic [NW-1:0] NUM = NW'(NUM_REF);

    logic [NW-1:0] sent;

    // request handshake and count of acknowledged refreshes
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            req  <= 1'b0;
            sent <= '0;
        end else if (req && ack) begin
            req  <= 1'b0;
            sent <= sent + 1'b1;
        end else if (!req && sent != NUM) begin
            req  <= 1'b1;
        end
    end

    // all ranks addressed, completion flag
    always_comb begin
        rank = {RANK_W{1'b1}};
        fin  = go && (sent == NUM);
    end
endmodule

// File: rtl/dqs_cal_fsm.sv
// Sequence controller: idle, save/zero interval, calibrate, refresh burst,
// restore. Both lanes done takes priority over the timeout in the same cycle.
// Assumes: the caller holds the memory controller in its configuration state.
module dqs_cal_fsm
    import dqs_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       lanes_done,
    input  logic       expire,
    input  logic       ref_fin,
    output seq_state_e state
);
    seq_state_e nxt;

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_SAVE;
            ST_SAVE:    nxt = ST_CAL;
            ST_CAL:     if (lanes_done) nxt = ST_REF;
                        else if (expire) nxt = ST_RESTORE;
            ST_REF:     if (ref_fin) nxt = ST_RESTORE;
            ST_RESTORE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/dqs_gate_cal_seq.sv
// DQS gate calibration sequencer (top).
// Suspends auto-refresh and runs PHY gate calibration. Afterwards it sends
// NUM_REF catch-up refreshes and restores the refresh interval.
// Assumes: ivl_rd_i shows the live interval register; the PHY clears its
// lane flags when the calibrate bit drops.
module dqs_gate_cal_seq
    import dqs_cal_pkg::*;
#(
    parameter int IVL_W       = 16,
    parameter int CAL_TIMEOUT = 2048,
    parameter int NUM_REF     = 3,
    parameter int RANK_W      = 2,
    parameter int LANES       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    input  logic [IVL_W-1:0]  ivl_rd_i,
    output logic              ivl_wr_en_o,
    output logic [IVL_W-1:0]  ivl_wr_data_o,
    output logic [1:0]        cal_ctrl_o,
    input  logic [LANES-1:0]  cal_stat_i,
    output logic              ref_req_o,
    output logic [RANK_W-1:0] ref_rank_o,
    input  logic              ref_ack_i
);
    seq_state_e       state;
    logic             lanes_done;
    logic             expire;
    logic             ref_fin;
    logic             in_cal;
    logic [IVL_W-1:0] saved_ivl;

    always_comb lanes_done = &cal_stat_i;
    always_comb in_cal     = (state == ST_CAL);

    dqs_cal_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .lanes_done (lanes_done),
        .expire     (expire),
        .ref_fin    (ref_fin),
        .state      (state)
    );

    dqs_cal_timer #(.TIMEOUT(CAL_TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (in_cal),
        .expire (expire)
    );

    dqs_cal_ref_issuer #(.NUM_REF(NUM_REF), .RANK_W(RANK_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (state == ST_REF),
        .ack   (ref_ack_i),
        .req   (ref_req_o),
        .rank  (ref_rank_o),
        .fin   (ref_fin)
    );

    // capture the live interval in the cycle it is overwritten with zero
    always_ff @(posedge clk) begin
        if (!rst_n)               saved_ivl <= '0;
        else if (state == ST_SAVE) saved_ivl <= ivl_rd_i;
    end

    // sticky timeout flag, cleared by an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)                          err_o <= 1'b0;
        else if (state == ST_IDLE && start_i) err_o <= 1'b0;
        else if (in_cal && !lanes_done && expire) err_o <= 1'b1;
    end

    // output decode from state
    always_comb begin
        busy_o                   = (state != ST_IDLE);
        done_o                   = (state == ST_RESTORE);
        ivl_wr_en_o              = (state == ST_SAVE) || (state == ST_RESTORE);
        ivl_wr_data_o            = (state == ST_RESTORE) ? saved_ivl : '0;
        cal_ctrl_o               = 2'b00;
        cal_ctrl_o[CAL_GO_BIT]   = in_cal;
        cal_ctrl_o[CAL_MODE_BIT] = 1'b0;
    end
endmodule

// File: rtl/dqs_gate_cal_seq_chk.sv
// Property checker for dqs_gate_cal_seq, attached by bind.
// Assumes: connected to the top module's ports only.
module dqs_gate_cal_seq_chk #(
    parameter int IVL_W   = 16,
    parameter int NUM_REF = 3,
    parameter int RANK_W  = 2,
    parameter int LANES   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              ivl_wr_en_o,
    input logic [IVL_W-1:0]  ivl_wr_data_o,
    input logic [1:0]        cal_ctrl_o,
    input logic [LANES-1:0]  cal_stat_i,
    input logic              ref_req_o,
    input logic [RANK_W-1:0] ref_rank_o,
    input logic              ref_ack_i
);
    logic       req_d;
    logic [7:0] req_seen;

    // count request rising edges within one sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d    <= 1'b0;
            req_seen <= '0;
        end else begin
            req_d <= ref_req_o;
            if (done_o)                 req_seen <= '0;
            else if (ref_req_o && !req_d) req_seen <= req_seen + 1'b1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ref_req_o && cal_ctrl_o == 2'b00 && !ivl_wr_en_o));

    // R2
    zero_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (ivl_wr_en_o && ivl_wr_data_o == '0));

    // R3
    cal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_ctrl_o[1]);

    // R3
    cal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ctrl_o[0] |-> (!ref_req_o && !ivl_wr_en_o));

    // R4
    both_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_ctrl_o[0]) |-> (&$past(cal_stat_i) || err_o));

    // R5
    ref_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> (&ref_rank_o));

    // R5
    ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (req_seen == 8'd0 || req_seen == 8'(NUM_REF)));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && !ref_ack_i) |=> ref_req_o);

    // R7
    restore_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ivl_wr_en_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

bind dqs_gate_cal_seq dqs_gate_cal_seq_chk #(
    .IVL_W(IVL_W), .NUM_REF(NUM_REF), .RANK_W(RANK_W), .LANES(LANES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .ivl_wr_en_o(ivl_wr_en_o),
    .ivl_wr_data_o(ivl_wr_data_o), .cal_ctrl_o(cal_ctrl_o),
    .cal_stat_i(cal_stat_i), .ref_req_o(ref_req_o), .ref_rank_o(ref_rank_o),
    .ref_ack_i(ref_ack_i)
);

// File: tb/dqs_gate_cal_seq_tb.sv
// Bench: models the PHY lanes, the refresh command port and the interval
// register, then sweeps lane delays, ack latencies and interval values.
module dqs_gate_cal_seq_tb;
    localparam int TO    = 40;
    localparam int NREF  = 3;
    localparam int NEVER = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, err_o;
    logic [15:0] ivl_model = '0;
    logic        ivl_wr_en_o;
    logic [15:0] ivl_wr_data_o;
    logic [1:0]  cal_ctrl_o;
    logic [1:0]  cal_stat = 2'b00;
    logic        ref_req_o;
    logic [1:0]  ref_rank_o;
    logic        ref_ack = 1'b0;

    int n_tests = 0, n_fail = 0;
    int dly_lo = 0, dly_hi = 0, ack_dly = 0;
    logic        ld = 1'b0;
    logic [15:0] ld_val = '0;

    always #2.5 clk = ~clk;

    dqs_gate_cal_seq #(.IVL_W(16), .CAL_TIMEOUT(TO), .NUM_REF(NREF), .RANK_W(2), .LANES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .ivl_rd_i(ivl_model),
        .ivl_wr_en_o(ivl_wr_en_o), .ivl_wr_data_o(ivl_wr_data_o),
        .cal_ctrl_o(cal_ctrl_o), .cal_stat_i(cal_stat),
        .ref_req_o(ref_req_o), .ref_rank_o(ref_rank_o), .ref_ack_i(ref_ack)
    );

    // interval register model
    always @(posedge clk) begin
        if (ld) ivl_model <= ld_val;
        else if (ivl_wr_en_o) ivl_model <= ivl_wr_data_o;
    end

    // PHY lane model: each lane reports after its own delay
    int pcnt = 0;
    always @(negedge clk) begin
        if (!cal_ctrl_o[0]) begin
            pcnt = 0;
            cal_stat = 2'b00;
        end else begin
            pcnt++;
            cal_stat[0] = (pcnt > dly_lo);
            cal_stat[1] = (pcnt > dly_hi);
        end
    end

    // refresh port model: one-cycle ack after ack_dly cycles
    int acnt = 0;
    always @(negedge clk) begin
        if (ref_ack) ref_ack = 1'b0;
        else if (ref_req_o) begin
            if (acnt >= ack_dly) begin ref_ack = 1'b1; acnt = 0; end
            else acnt++;
        end
    end

    // monitor, cumulative counters
    int cyc = 0, wr_cnt = 0, cal_hi = 0, mode_bad = 0, ref_cnt = 0;
    int rank_bad = 0, done_cnt = 0, order_bad = 0, early_end = 0;
    int last_ack_cyc = 0, last_wr_cyc = 0;
    logic [15:0] first_wr = '0, last_wr = '0;
    logic prev_req = 1'b0, prev_cal = 1'b0;
    logic [1:0] prev_stat = 2'b00;
    int seq_wr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ivl_wr_en_o) begin
                if (seq_wr == 0) first_wr = ivl_wr_data_o;
                last_wr = ivl_wr_data_o;
                last_wr_cyc = cyc;
                wr_cnt++;
                seq_wr++;
            end
            if (cal_ctrl_o[0]) begin
                cal_hi++;
                if (seq_wr == 0) order_bad++;
            end
            if (cal_ctrl_o[1]) mode_bad++;
            if (ref_req_o && !prev_req) ref_cnt++;
            if (ref_req_o && ref_rank_o != 2'b11) rank_bad++;
            if (ref_req_o && ref_ack) last_ack_cyc = cyc;
            if (prev_cal && !cal_ctrl_o[0] && prev_stat != 2'b11) early_end++;
            if (done_o) begin done_cnt++; seq_wr = 0; end
            prev_req  = ref_req_o;
            prev_cal  = cal_ctrl_o[0];
            prev_stat = cal_stat;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input logic [15:0] val, input int lo, input int hi,
                           input int adly, input bit poke);
        int s_wr, s_cal, s_mode, s_ref, s_rank, s_done, s_order, s_early;
        bit to_exp;
        int mx;
        to_exp = (lo >= NEVER) || (hi >= NEVER);
        mx = (lo > hi) ? lo : hi;
        @(posedge clk); #1;
        ld = 1'b1; ld_val = val; dly_lo = lo; dly_hi = hi; ack_dly = adly;
        @(posedge clk); #1;
        ld = 1'b0;
        s_wr = wr_cnt; s_cal = cal_hi; s_mode = mode_bad; s_ref = ref_cnt;
        s_rank = rank_bad; s_done = done_cnt; s_order = order_bad; s_early = early_end;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(posedge clk); #1;
            start_i = (poke && k == 4);
            if (done_cnt != s_done) break;
        end
        start_i = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(done_cnt - s_done == 1, "R9 one done pulse", done_cnt - s_done, 1);
        chk(!busy_o, "R9 idle after done / start while busy ignored", busy_o, 0);
        chk(wr_cnt - s_wr == 2, "R2/R7 interval writes", wr_cnt - s_wr, 2);
        chk(first_wr == 16'h0, "R2 first write zero", first_wr, 0);
        chk(order_bad == s_order, "R2 zero before calibrate", order_bad - s_order, 0);
        chk(last_wr == val && ivl_model == val, "R7 interval restored", ivl_model, val);
        chk(mode_bad == s_mode, "R3 mode bit normal", mode_bad - s_mode, 0);
        chk(rank_bad == s_rank, "R5 all-rank refresh", rank_bad - s_rank, 0);
        if (to_exp) begin
            chk(cal_hi - s_cal == TO, "R8 timeout window", cal_hi - s_cal, TO);
            chk(ref_cnt == s_ref, "R8 no refresh on timeout", ref_cnt - s_ref, 0);
            chk(err_o, "R8 error set", err_o, 1);
            repeat (5) @(posedge clk);
            #1;
            chk(err_o, "R10 error held", err_o, 1);
        end else begin
            chk(early_end == s_early, "R4 both lanes required", early_end - s_early, 0);
            chk(cal_hi - s_cal >= mx + 1, "R4 cal held until slower lane", cal_hi - s_cal, mx + 1);
            chk(ref_cnt - s_ref == NREF, "R5 refresh count", ref_cnt - s_ref, NREF);
            chk(last_wr_cyc > last_ack_cyc, "R6/R7 restore after last ack", last_wr_cyc, last_ack_cyc + 1);
            chk(!err_o, "R10 error clear", err_o, 0);
        end
    endtask

    initial begin
        logic [15:0] vals [4];
        int dl [3];
        int ix;
        bit wd_hit;
        vals[0] = 16'h018c; vals[1] = 16'h0000; vals[2] = 16'hffff; vals[3] = 16'h0001;
        dl[0] = 0; dl[1] = 2; dl[2] = 7;
        wd_hit = 1'b0;
        ix = 0;
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                #1;
                chk(!busy_o && !done_o && !err_o && !ivl_wr_en_o && !ref_req_o && cal_ctrl_o == 2'b00,
                    "R1 reset state", {busy_o, done_o, err_o, ivl_wr_en_o, ref_req_o, cal_ctrl_o}, 0);
                for (int a = 0; a < 3; a++)
                    for (int b = 0; b < 3; b++)
                        for (int c = 0; c < 2; c++) begin
                            run_seq(vals[ix % 4], dl[a], dl[b], c * 3, (a == 1 && c == 1));
                            ix++;
                        end
                // R8 timeouts: each lane missing, then both
                run_seq(16'h1234, NEVER, 1, 0, 1'b0);
                run_seq(16'h00ff, 1, NEVER, 2, 1'b1);
                // R10 cleared by a good run after timeout
                run_seq(16'h0abc, 3, 3, 1, 1'b0);
                run_seq(16'h7777, NEVER, NEVER, 0, 1'b0);
                run_seq(16'h5555, 0, 0, 0, 1'b0);
            end
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        if (wd_hit) chk(1'b0, "watchdog", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule